// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block keeps an asynchronous DRAM alive on behalf of the rest of a chip. After reset it waits a start-up delay and then runs a fixed burst of warm-up refresh cycles. Only after both are done does it raise `ready`, which tells the access controller that normal reads and writes may begin. After that, an interval timer adds one owed refresh per tick. Each owed refresh is paid with one refresh cycle on the DRAM bus.

Each refresh is a CAS-before-RAS cycle, so the device's internal row counter selects the row and no address is driven. The sequencer shares the strobes with an access controller through a four-phase request/grant handshake. It drives RAS and CAS only while it holds the grant. Refreshes that cannot run because the bus is busy pile up in a backlog counter, which is worked off later. When the backlog reaches its limit, an urgent flag asks the arbiter for priority.

All timing values are counts of clock cycles, set by parameters. The defaults suit a 50 MHz clock: a 200 µs start-up delay, eight warm-up refreshes, a tick every 15.6 µs (4096 refreshes per 64 ms), a RAS-low time of at least 50 ns and a precharge of at least 30 ns.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and on leaving it, `ras_n`, `cas_n` and `we_n` are 1, and `bus_req`, `ready` and `urgent` are 0.
- R2: For at least STARTUP_CYC cycles after reset is released, `bus_req` stays 0 and both strobes stay high.
- R3: After the start-up delay, exactly WARMUP_CNT refresh cycles are completed before `ready` rises. Once high, `ready` never falls until the next reset.
- R4: `ras_n` or `cas_n` is low only while both `bus_req` and `bus_gnt` are 1.
- R5: In every refresh cycle `cas_n` falls first. It stays low alone for exactly CAS_LEAD cycles before `ras_n` falls. `ras_n` never falls while `cas_n` is high.
- R6: `we_n` is 1 at all times, so a refresh can never enter the device's test mode.
- R7: `ras_n` stays low for exactly RAS_LOW_CYC cycles per refresh, with `cas_n` low throughout. Both strobes rise together.
- R8: `bus_req` falls only after both strobes have been high for RAS_PRE_CYC cycles.
- R9: Once `ready` is high, each interval of INTERVAL_CYC cycles adds one owed refresh. With a prompt grant, exactly one refresh cycle follows each tick.
- R10: The backlog saturates at BACKLOG_MAX. `urgent` is 1 exactly while the backlog is at that limit. When the grant returns, exactly BACKLOG_MAX refreshes are run to catch up, and `urgent` clears.
- R11: `bus_req` rises only when `bus_gnt` was 0 in the previous cycle. After releasing the bus, the sequencer waits for the grant to drop before it asks again.
- R12: While the grant is withheld, `bus_req` stays 1 and both strobes stay high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_gnt | input | 1 | Grant of the DRAM bus from the arbiter |
| bus_req | output | 1 | Request for the DRAM bus |
| ras_n | output | 1 | Row strobe to the DRAM, active low |
| cas_n | output | 1 | Column strobe to the DRAM, active low |
| we_n | output | 1 | Write enable to the DRAM, held high |
| ready | output | 1 | Initialization complete; normal access allowed |
| urgent | output | 1 | Refresh backlog at its limit; priority requested |

## Verification
The bench builds the block with STARTUP_CYC=20, WARMUP_CNT=8, INTERVAL_CYC=100, BACKLOG_MAX=3, CAS_LEAD=2, RAS_LOW_CYC=3 and RAS_PRE_CYC=2. This shortens the start-up wait to a few hundred nanoseconds while keeping the full eight-cycle warm-up burst. The short interval lets the backlog reach its limit within a few hundred cycles of withholding the grant. Because the catch-up burst of three refreshes fits well inside one interval, the number of catch-up cycles can be counted exactly. A CAS lead of two cycles makes the CAS-before-RAS ordering measurable. A slow grant release during catch-up exercises the four-phase wait.

// File: rtl/refresh_pkg.sv
// Package: shared types for the DRAM refresh sequencer.
package refresh_pkg;

    // Phases of the refresh sequencer.
    typedef enum logic [2:0] {
        SQ_STARTUP = 3'd0,  // counting the power-up delay
        SQ_IDLE    = 3'd1,  // nothing owed or deciding to request
        SQ_REQ     = 3'd2,  // bus requested, waiting for grant
        SQ_CAS     = 3'd3,  // CAS low, RAS high (CAS-before-RAS lead)
        SQ_RAS     = 3'd4,  // RAS and CAS both low
        SQ_PRE     = 3'd5,  // both high, precharge still holding the bus
        SQ_REL     = 3'd6   // request dropped, waiting for grant to drop
    } seq_state_t;

endpackage

// File: rtl/refresh_interval_timer.sv
// Module: refresh_interval_timer
// Emits a one-cycle tick every INTERVAL_CYC cycles while enabled.
// Assumes INTERVAL_CYC >= 2. When disabled, the count is held at zero,
// so the first tick comes a full interval after enable.
module refresh_interval_timer #(
    parameter int INTERVAL_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(INTERVAL_CYC);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Purpose: free-running interval count while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + TW'(1);
        end
    end

    // Purpose: tick on the last count of each interval.
    always_comb begin
        tick = en && (cnt_q == LAST);
    end
endmodule

// File: rtl/refresh_backlog.sv
// Module: refresh_backlog
// Counts refreshes owed: +1 per interval tick, -1 per completed refresh,
// saturating at BACKLOG_MAX and never going below zero. A tick and a
// completion in the same cycle cancel out. Flags urgency at the limit.
module refresh_backlog #(
    parameter int BACKLOG_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic pending,
    output logic urgent
);
    localparam int BW = $clog2(BACKLOG_MAX + 1);
    localparam logic [BW-1:0] TOP = BW'(BACKLOG_MAX);

    logic [BW-1:0] owed_q;

    // Purpose: saturating up/down count of owed refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed_q <= '0;
        end else if (inc && !dec && owed_q != TOP) begin
            owed_q <= owed_q + BW'(1);
        end else if (dec && !inc && owed_q != '0) begin
            owed_q <= owed_q - BW'(1);
        end
    end

    // Purpose: status decoded from the owed count.
    always_comb begin
        pending = (owed_q != '0);
        urgent  = (owed_q == TOP);
    end
endmodule

// File: rtl/cbr_sequencer.sv
// Module: cbr_sequencer
// Runs the start-up delay, the warm-up burst and each CAS-before-RAS
// refresh cycle under a four-phase request/grant handshake.
// Assumes the arbiter holds bus_gnt high until bus_req falls.
// All strobe and request outputs come straight from flops.
module cbr_sequencer
    import refresh_pkg::*;
#(
    parameter int STARTUP_CYC = 10000,
    parameter int WARMUP_CNT  = 8,
    parameter int CAS_LEAD    = 1,
    parameter int RAS_LOW_CYC = 3,
    parameter int RAS_PRE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic bus_gnt,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic ready,
    output logic done_pulse
);
    localparam int M1 = (STARTUP_CYC > CAS_LEAD) ? STARTUP_CYC : CAS_LEAD;
    localparam int M2 = (RAS_LOW_CYC > RAS_PRE_CYC) ? RAS_LOW_CYC : RAS_PRE_CYC;
    localparam int LIM_MAX = (M1 > M2) ? M1 : M2;
    localparam int CW = $clog2(LIM_MAX + 1);
    localparam int WW = $clog2(WARMUP_CNT + 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, lim;
    logic          last;
    logic [WW-1:0] warm_q;
    logic          warm_busy;
    logic          ras_n_q, cas_n_q, req_q, ready_q;

    // Purpose: per-phase duration limit and end-of-phase flag.
    always_comb begin
        case (state_q)
            SQ_STARTUP: lim = CW'(STARTUP_CYC);
            SQ_CAS:     lim = CW'(CAS_LEAD);
            SQ_RAS:     lim = CW'(RAS_LOW_CYC);
            SQ_PRE:     lim = CW'(RAS_PRE_CYC);
            default:    lim = CW'(1);
        endcase
        last      = (cnt_q == lim - CW'(1));
        warm_busy = (warm_q != '0);
    end

    // Purpose: next-phase decision.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_STARTUP: if (last) state_d = SQ_IDLE;
            SQ_IDLE:    if (warm_busy || pending) state_d = SQ_REQ;
            SQ_REQ:     if (bus_gnt) state_d = SQ_CAS;
            SQ_CAS:     if (last) state_d = SQ_RAS;
            SQ_RAS:     if (last) state_d = SQ_PRE;
            SQ_PRE:     if (last) state_d = SQ_REL;
            SQ_REL:     if (!bus_gnt) state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
    end

    // Purpose: phase register and in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_STARTUP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q inside {SQ_STARTUP, SQ_CAS, SQ_RAS, SQ_PRE}) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // Purpose: count down the warm-up burst at the end of each RAS phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= WW'(WARMUP_CNT);
        end else if (state_q == SQ_RAS && last && warm_busy) begin
            warm_q <= warm_q - WW'(1);
        end
    end

    // Purpose: registered strobes and request, decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n_q <= 1'b1;
            cas_n_q <= 1'b1;
            req_q   <= 1'b0;
        end else begin
            ras_n_q <= (state_d != SQ_RAS);
            cas_n_q <= !(state_d inside {SQ_CAS, SQ_RAS});
            req_q   <= (state_d inside {SQ_REQ, SQ_CAS, SQ_RAS, SQ_PRE});
        end
    end

    // Purpose: sticky ready once idle with the warm-up burst done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (state_q == SQ_IDLE && !warm_busy) begin
            ready_q <= 1'b1;
        end
    end

    // Purpose: output wiring; a completion pulse only for scheduled refreshes.
    always_comb begin
        ras_n      = ras_n_q;
        cas_n      = cas_n_q;
        bus_req    = req_q;
        ready      = ready_q;
        done_pulse = (state_q == SQ_RAS) && last && !warm_busy;
    end
endmodule

// File: rtl/dram_refresh_seq.sv
// Module: dram_refresh_seq (top)
// DRAM refresh and initialization sequencer: start-up delay, warm-up
// burst, then one CAS-before-RAS refresh per interval tick, with a
// saturating backlog for refreshes postponed by a busy bus.
// Assumes timing parameters are clock-cycle counts, each >= 1, and
// INTERVAL_CYC >= 2. Write enable is held high so that no refresh
// enters the device's test mode.
module dram_refresh_seq #(
    parameter int STARTUP_CYC  = 10000,
    parameter int WARMUP_CNT   = 8,
    parameter int INTERVAL_CYC = 780,
    parameter int BACKLOG_MAX  = 8,
    parameter int CAS_LEAD     = 1,
    parameter int RAS_LOW_CYC  = 3,
    parameter int RAS_PRE_CYC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    output logic bus_req,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic ready,
    output logic urgent
);
    logic tick, pending, done_pulse;

    // Purpose: interval timer runs only once initialization is over.
    refresh_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (ready),
        .tick (tick)
    );

    // Purpose: owed-refresh count and urgency.
    refresh_backlog #(
        .BACKLOG_MAX(BACKLOG_MAX)
    ) u_backlog (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (tick),
        .dec    (done_pulse),
        .pending(pending),
        .urgent (urgent)
    );

    // Purpose: phase machine that drives the strobes.
    cbr_sequencer #(
        .STARTUP_CYC(STARTUP_CYC),
        .WARMUP_CNT (WARMUP_CNT),
        .CAS_LEAD   (CAS_LEAD),
        .RAS_LOW_CYC(RAS_LOW_CYC),
        .RAS_PRE_CYC(RAS_PRE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .ready     (ready),
        .done_pulse(done_pulse)
    );

    // Purpose: write enable is never asserted by a refresh.
    assign we_n = 1'b1;
endmodule

// File: rtl/refresh_seq_checker.sv
// Module: refresh_seq_checker
// Protocol properties of the refresh sequencer, observed at its ports.
// Duration windows are measured with local counters, not $past depth.
module refresh_seq_checker #(
    parameter int RAS_LOW_CYC = 3,
    parameter int RAS_PRE_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_gnt,
    input logic ras_n,
    input logic cas_n,
    input logic ready
);
    logic [7:0] low_run, pre_run;

    // Purpose: length of the current RAS-low stretch.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n) low_run <= '0;
        else if (low_run != 8'hFF) low_run <= low_run + 8'd1;
    end

    // Purpose: length of the current all-high stretch while holding the bus.
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_n || !cas_n || !bus_req) pre_run <= '0;
        else if (pre_run != 8'hFF) pre_run <= pre_run + 8'd1;
    end

    assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(ready));

    assert_strobe_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> (bus_req && bus_gnt));

    assert_cas_before_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    assert_ras_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (low_run == 8'(RAS_LOW_CYC) && cas_n));

    assert_precharge_before_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> (ras_n && cas_n && pre_run >= 8'(RAS_PRE_CYC)));

    assert_four_phase_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !$past(bus_gnt));
endmodule

bind dram_refresh_seq refresh_seq_checker #(
    .RAS_LOW_CYC(RAS_LOW_CYC),
    .RAS_PRE_CYC(RAS_PRE_CYC)
) u_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_req(bus_req),
    .bus_gnt(bus_gnt),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .ready  (ready)
);

// File: tb/tb_dram_refresh_seq.sv
// Scoreboard bench: the main flow pushes the expected shape of each
// refresh cycle; a monitor measures every cycle on the strobes and
// compares it against the next expected item.
module tb_dram_refresh_seq;
    localparam int STARTUP_CYC  = 20;
    localparam int WARMUP_CNT   = 8;
    localparam int INTERVAL_CYC = 100;
    localparam int BACKLOG_MAX  = 3;
    localparam int CAS_LEAD     = 2;
    localparam int RAS_LOW_CYC  = 3;
    localparam int RAS_PRE_CYC  = 2;

    typedef struct {
        int lead;
        int low;
        int pre;
    } shape_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_gnt = 1'b0;
    logic bus_req, ras_n, cas_n, we_n, ready, urgent;

    int n_chk = 0;
    int n_bad = 0;
    shape_t exp_q[$];
    int seen = 0;

    bit gnt_en = 1'b1;
    int drop_dly = 0;

    always #10 clk = ~clk;

    dram_refresh_seq #(
        .STARTUP_CYC (STARTUP_CYC),
        .WARMUP_CNT  (WARMUP_CNT),
        .INTERVAL_CYC(INTERVAL_CYC),
        .BACKLOG_MAX (BACKLOG_MAX),
        .CAS_LEAD    (CAS_LEAD),
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .RAS_PRE_CYC (RAS_PRE_CYC)
    ) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_gnt(bus_gnt),
        .bus_req(bus_req),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .ready  (ready),
        .urgent (urgent)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push_refreshes(input int n);
        for (int i = 0; i < n; i++) begin
            shape_t s;
            s.lead = CAS_LEAD;
            s.low  = RAS_LOW_CYC;
            s.pre  = RAS_PRE_CYC;
            exp_q.push_back(s);
        end
    endtask

    // Arbiter model: grants when enabled, drops drop_dly cycles after release.
    int rel_cnt = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_gnt <= 1'b0;
            rel_cnt = 0;
        end else if (bus_req && gnt_en) begin
            bus_gnt <= 1'b1;
            rel_cnt = 0;
        end else if (!bus_req && bus_gnt) begin
            if (rel_cnt >= drop_dly) bus_gnt <= 1'b0;
            else rel_cnt++;
        end
    end

    // Monitor: measures each refresh cycle and pops the scoreboard.
    int ph = 0, lead = 0, low = 0, pre = 0;
    bit we_ok = 1'b1, gnt_ok = 1'b1, cas_ok = 1'b1;
    bit prev_gnt = 1'b0, prev_req = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_n) we_ok = 1'b0;
            if ((!ras_n || !cas_n) && !(bus_gnt && bus_req)) gnt_ok = 1'b0;
            if (bus_req && !prev_req)
                check(!prev_gnt, "R11 request only after grant low", prev_gnt, 0);
            case (ph)
                0: begin
                    if (!ras_n) cas_ok = 1'b0;
                    if (!cas_n) begin ph = 1; lead = 1; end
                end
                1: if (!ras_n) begin ph = 2; low = 1; end else lead++;
                2: begin
                    if (ras_n) begin
                        if (!cas_n) cas_ok = 1'b0;
                        ph = 3;
                        pre = bus_req ? 1 : 0;
                    end else begin
                        if (cas_n) cas_ok = 1'b0;
                        low++;
                    end
                end
                default: if (bus_req) pre++;
            endcase
            if (ph == 3 && !bus_req) begin
                seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected refresh cycle", seen, 0);
                end else begin
                    shape_t e;
                    e = exp_q.pop_front();
                    check(lead == e.lead, "R5 CAS lead cycles", lead, e.lead);
                    check(low == e.low, "R7 RAS low cycles", low, e.low);
                    check(pre == e.pre, "R8 precharge before release", pre, e.pre);
                end
                check(cas_ok, "R5 CAS low before and during RAS", cas_ok, 1);
                check(we_ok, "R6 write enable high", we_ok, 1);
                check(gnt_ok, "R4 strobes only under grant", gnt_ok, 1);
                cas_ok = 1'b1;
                ph = 0;
            end
        end
        prev_gnt = bus_gnt;
        prev_req = bus_req;
    end

    // Watchdog: a hung run counts as a failure and still summarizes.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int wait_cyc;
        bit quiet;
        // R1: reset values
        repeat (4) @(negedge clk);
        check(ras_n === 1'b1, "R1 ras_n in reset", ras_n, 1);
        check(cas_n === 1'b1, "R1 cas_n in reset", cas_n, 1);
        check(we_n === 1'b1, "R1 we_n in reset", we_n, 1);
        check(bus_req === 1'b0, "R1 bus_req in reset", bus_req, 0);
        check(ready === 1'b0, "R1 ready in reset", ready, 0);
        check(urgent === 1'b0, "R1 urgent in reset", urgent, 0);

        push_refreshes(WARMUP_CNT);
        rst_n = 1'b1;

        // R2: nothing happens during the start-up delay
        wait_cyc = 0;
        quiet = 1'b1;
        @(negedge clk);
        check(ras_n && cas_n && !bus_req && !ready, "R1 outputs after release", bus_req, 0);
        while (!bus_req && wait_cyc < 200) begin
            if (!ras_n || !cas_n) quiet = 1'b0;
            wait_cyc++;
            @(negedge clk);
        end
        check(wait_cyc >= STARTUP_CYC && wait_cyc <= STARTUP_CYC + 2,
              "R2 start-up delay cycles", wait_cyc, STARTUP_CYC);
        check(quiet, "R2 strobes high during start-up", quiet, 1);

        // R3: ready rises only after the whole warm-up burst
        wait_cyc = 0;
        while (!ready && wait_cyc < 2000) begin
            wait_cyc++;
            @(negedge clk);
        end
        check(seen == WARMUP_CNT, "R3 warm-up refreshes before ready", seen, WARMUP_CNT);
        check(exp_q.size() == 0, "R3 warm-up queue drained", exp_q.size(), 0);

        // R9: one refresh per interval with a prompt grant
        push_refreshes(3);
        repeat (3 * INTERVAL_CYC + 50) @(negedge clk);
        check(exp_q.size() == 0, "R9 refreshes over three intervals", exp_q.size(), 0);
        check(seen == WARMUP_CNT + 3, "R9 total refresh count", seen, WARMUP_CNT + 3);
        check(ready == 1'b1, "R3 ready stays high", ready, 1);

        // R12 / R10: withhold the grant until the backlog saturates
        gnt_en = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < (BACKLOG_MAX + 2) * INTERVAL_CYC - 30; i++) begin
            @(negedge clk);
            if (!ras_n || !cas_n) quiet = 1'b0;
            if (i == 60) begin
                check(bus_req == 1'b1, "R12 request held while stalled", bus_req, 1);
                check(urgent == 1'b0, "R10 urgent low below limit", urgent, 0);
            end
        end
        check(quiet, "R12 strobes high while grant withheld", quiet, 1);
        check(bus_req == 1'b1, "R12 request still held", bus_req, 1);
        check(urgent == 1'b1, "R10 urgent at backlog limit", urgent, 1);

        // R10 / R11: catch-up burst with a slow grant release
        push_refreshes(BACKLOG_MAX);
        drop_dly = 3;
        gnt_en = 1'b1;
        repeat (70) @(negedge clk);
        check(exp_q.size() == 0, "R10 catch-up refreshes run", exp_q.size(), 0);
        check(seen == WARMUP_CNT + 3 + BACKLOG_MAX, "R10 catch-up count", seen,
              WARMUP_CNT + 3 + BACKLOG_MAX);
        check(urgent == 1'b0, "R10 urgent cleared after catch-up", urgent, 0);
        check(bus_req == 1'b0, "R10 bus released after catch-up", bus_req, 0);
        check(we_n == 1'b1, "R6 write enable high at end", we_n, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule